// File: doc/BRIEF.md
# Voltage-Current Supervisor State Machine

This block decides whether a closed-loop voltage-current controller may act. It holds the loop idle after reset until a start request arrives, lets it run, and stops it the moment any fault condition is seen. Fault sources are voltage and current samples that exceed limit values, along with a set of asynchronous fault lines. When the loop is stopped, downstream actuators are told to go to their safe level.

Each voltage or current sample comes with a valid strobe and is compared against its limit on the control clock. The comparison result is held in a flag until the next valid sample on that channel. Asynchronous fault lines pass through a two-flop synchronizer before the state logic sees them. A clear request moves the machine out of FAULT straight back to RUN, without re-initialization, but only when every fault source has gone quiet.

The block exposes a control-enable output, a force-safe output and a 2-bit state code. Reset is asserted asynchronously (active low) and released synchronously to the clock.

Top module: `vi_supervisor`

## Requirements
- R1: The state code takes only three values: INIT=2'b00, RUN=2'b01, FAULT=2'b10. The value 2'b11 never appears.
- R2: After reset the state is INIT. INIT moves to RUN only on a start request. A clear request in INIT has no effect.
- R3: In RUN, any active fault source moves the state to FAULT on the next clock edge.
- R4: In FAULT, a clear request while any synchronized fault is still active is ignored. A start request in FAULT has no effect, and the state does not leave FAULT on its own.
- R5: In FAULT, a clear request with no active fault moves the state to RUN.
- R6: A voltage fault is flagged when a sample with its valid strobe is strictly greater than the voltage limit. A sample equal to the limit, or a sample without its strobe, raises no fault. The flag holds until the next valid voltage sample. An over-limit sample in RUN shows as FAULT two clock edges later.
- R7: The current channel follows the same rule as R6, using its own sample, strobe and limit.
- R8: Each asynchronous fault line goes through a two-flop synchronizer. A line raised while in RUN puts the state in FAULT on the third rising edge after the line is first sampled.
- R9: ctrl_en is high only in RUN. force_safe is high in INIT and in FAULT. The two are never high together.
- R10: If a fault and a start request reach the state logic in the same INIT cycle, the state goes to FAULT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_req | input | 1 | Request to leave INIT for RUN |
| clear_req | input | 1 | Request to return from FAULT to RUN |
| async_fault | input | N_ASYNC (2) | Asynchronous fault lines, active high |
| v_sample | input | SAMPLE_W (12) | Voltage sample, unsigned |
| v_valid | input | 1 | Voltage sample strobe |
| v_limit | input | SAMPLE_W (12) | Voltage upper limit |
| i_sample | input | SAMPLE_W (12) | Current sample, unsigned |
| i_valid | input | 1 | Current sample strobe |
| i_limit | input | SAMPLE_W (12) | Current upper limit |
| ctrl_en | output | 1 | Control loop enable |
| force_safe | output | 1 | Drive actuators to their safe level |
| state_code | output | 2 | Current state code |

## Verification
A wrong internal state shows at the ports without delay: ctrl_en, force_safe and state_code all decode the state register, so a bad transition appears in the cycle after the edge that caused it. A fault flag stuck high holds the machine in FAULT against every clear request, and one stuck low lets an over-limit sample pass with RUN still showing two edges later. A synchronizer with the wrong depth moves the FAULT entry off the third edge, so the timing of that transition is checked at exact cycles.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    ST_INIT  = 2'b00,
    ST_RUN   = 2'b01,
    ST_FAULT = 2'b10
  } sup_state_e;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/limit_monitor.sv
module limit_monitor #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sample,
  input  logic         valid,
  input  logic [W-1:0] limit,
  output logic         over
);
  logic over_nxt;

  always_comb begin
    over_nxt = over;
    if (valid) over_nxt = (sample > limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) over <= 1'b0;
    else        over <= over_nxt;
  end
endmodule

// File: rtl/sup_fsm.sv
module sup_fsm
  import sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_req,
  input  logic       clear_req,
  input  logic       fault_any,
  output sup_state_e state
);
  sup_state_e state_nxt;

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_INIT: begin
        if (fault_any)      state_nxt = ST_FAULT;
        else if (start_req) state_nxt = ST_RUN;
      end
      ST_RUN: begin
        if (fault_any) state_nxt = ST_FAULT;
      end
      ST_FAULT: begin
        if (clear_req && !fault_any) state_nxt = ST_RUN;
      end
      default: state_nxt = ST_FAULT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_INIT;
    else        state <= state_nxt;
  end
endmodule

// File: rtl/vi_supervisor.sv
module vi_supervisor
  import sup_pkg::*;
#(
  parameter int SAMPLE_W    = 12,
  parameter int N_ASYNC     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_req,
  input  logic                clear_req,
  input  logic [N_ASYNC-1:0]  async_fault,
  input  logic [SAMPLE_W-1:0] v_sample,
  input  logic                v_valid,
  input  logic [SAMPLE_W-1:0] v_limit,
  input  logic [SAMPLE_W-1:0] i_sample,
  input  logic                i_valid,
  input  logic [SAMPLE_W-1:0] i_limit,
  output logic                ctrl_en,
  output logic                force_safe,
  output logic [1:0]          state_code
);
  localparam int N_SRC = N_ASYNC + 2;

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [N_SRC-1:0] fault_vec;
  logic             fault_any;
  sup_state_e       state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  for (genvar g = 0; g < N_ASYNC; g++) begin : g_async
    sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .d    (async_fault[g]),
      .q    (fault_vec[g])
    );
  end

  limit_monitor #(.W(SAMPLE_W)) u_vmon (
    .clk(clk), .rst_n(rst_sync_n), .sample(v_sample), .valid(v_valid),
    .limit(v_limit), .over(fault_vec[N_ASYNC])
  );

  limit_monitor #(.W(SAMPLE_W)) u_imon (
    .clk(clk), .rst_n(rst_sync_n), .sample(i_sample), .valid(i_valid),
    .limit(i_limit), .over(fault_vec[N_ASYNC+1])
  );

  assign fault_any = |fault_vec;

  sup_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_req(start_req),
    .clear_req(clear_req),
    .fault_any(fault_any),
    .state    (state)
  );

  assign state_code = state;
  assign ctrl_en    = (state == ST_RUN);
  assign force_safe = (state != ST_RUN);
endmodule

// File: rtl/vi_supervisor_checker.sv
module vi_supervisor_checker #(
  parameter int SAMPLE_W = 12,
  parameter int N_ASYNC  = 2
) (
  input logic                clk,
  input logic                rst_sync_n,
  input logic                start_req,
  input logic                clear_req,
  input logic [N_ASYNC-1:0]  async_fault,
  input logic [SAMPLE_W-1:0] v_sample,
  input logic                v_valid,
  input logic [SAMPLE_W-1:0] v_limit,
  input logic [SAMPLE_W-1:0] i_sample,
  input logic                i_valid,
  input logic [SAMPLE_W-1:0] i_limit,
  input logic                fault_any,
  input logic                ctrl_en,
  input logic                force_safe,
  input logic [1:0]          state_code
);
  assert_legal_code_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    state_code != 2'b11);

  assert_start_only_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_code == 2'b00 && !start_req) |=> state_code != 2'b01);

  assert_fault_stops_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_code == 2'b01 && fault_any) |=> state_code == 2'b10);

  assert_clear_blocked_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_code == 2'b10 && fault_any) |=> state_code == 2'b10);

  assert_clear_resumes_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_code == 2'b10 && clear_req && !fault_any) |=> state_code == 2'b01);

  assert_over_volt_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_code == 2'b01 && v_valid && v_sample > v_limit) |-> ##2 state_code == 2'b10);

  assert_over_curr_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_code == 2'b01 && i_valid && i_sample > i_limit) |-> ##2 state_code == 2'b10);

  assert_sync_latency_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_code == 2'b01 && |async_fault) |-> ##3 state_code == 2'b10);

  assert_outputs_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctrl_en != force_safe);

  assert_fault_wins_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_code == 2'b00 && fault_any && start_req) |=> state_code == 2'b10);
endmodule

bind vi_supervisor vi_supervisor_checker #(.SAMPLE_W(SAMPLE_W), .N_ASYNC(N_ASYNC)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .start_req(start_req), .clear_req(clear_req),
  .async_fault(async_fault), .v_sample(v_sample), .v_valid(v_valid), .v_limit(v_limit),
  .i_sample(i_sample), .i_valid(i_valid), .i_limit(i_limit), .fault_any(fault_any),
  .ctrl_en(ctrl_en), .force_safe(force_safe), .state_code(state_code)
);

// File: tb/tb_vi_supervisor.sv
module tb_vi_supervisor;
  localparam int W = 12;
  localparam logic [1:0] S_I = 2'b00, S_R = 2'b01, S_F = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0, clear_req = 1'b0;
  logic [1:0] async_fault = 2'b00;
  logic [W-1:0] v_sample = '0, i_sample = '0;
  logic v_valid = 1'b0, i_valid = 1'b0;
  logic [W-1:0] v_limit = 12'd1000, i_limit = 12'd500;
  logic ctrl_en, force_safe;
  logic [1:0] state_code;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vi_supervisor dut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .clear_req(clear_req),
    .async_fault(async_fault), .v_sample(v_sample), .v_valid(v_valid), .v_limit(v_limit),
    .i_sample(i_sample), .i_valid(i_valid), .i_limit(i_limit),
    .ctrl_en(ctrl_en), .force_safe(force_safe), .state_code(state_code)
  );

  // vector: start, clear, async[1:0], v_valid, v[11:0], i_valid, i[11:0], expected state[1:0]
  function automatic logic [31:0] mk(logic st, logic cl, logic [1:0] af, logic vv,
                                     logic [11:0] v, logic iv, logic [11:0] i, logic [1:0] ex);
    return {st, cl, af, vv, v, iv, i, ex};
  endfunction

  localparam int NV = 17;
  localparam logic [31:0] VEC [0:NV-1] = '{
    mk(0,1,2'b00,0,12'd0,   0,12'd0,  2'b00), // R2 clear in INIT ignored
    mk(1,0,2'b00,0,12'd0,   0,12'd0,  2'b01), // R2 start
    mk(0,0,2'b00,1,12'd1000,0,12'd0,  2'b01), // R6 equal to limit
    mk(0,0,2'b00,0,12'd4000,0,12'd0,  2'b01), // R6 no strobe
    mk(0,0,2'b00,1,12'd1001,0,12'd0,  2'b10), // R6 over limit
    mk(0,1,2'b00,0,12'd0,   0,12'd0,  2'b10), // R4 flag held, clear ignored
    mk(0,0,2'b00,1,12'd900, 0,12'd0,  2'b10), // R4 no self recovery
    mk(0,1,2'b00,0,12'd0,   0,12'd0,  2'b01), // R5 clear
    mk(0,0,2'b00,0,12'd0,   1,12'd501,2'b10), // R7 over current
    mk(0,1,2'b00,0,12'd0,   1,12'd10, 2'b01), // R7 flag drops, R5 clear
    mk(0,0,2'b00,0,12'd0,   1,12'd500,2'b01), // R7 equal to limit
    mk(0,0,2'b01,0,12'd0,   0,12'd0,  2'b10), // R3 async line 0
    mk(0,1,2'b01,0,12'd0,   0,12'd0,  2'b10), // R4 clear while active
    mk(0,1,2'b00,0,12'd0,   0,12'd0,  2'b01), // R5 clear after release
    mk(1,0,2'b00,0,12'd0,   0,12'd0,  2'b01), // R3 start in RUN no effect
    mk(0,0,2'b10,0,12'd0,   0,12'd0,  2'b10), // R3 async line 1
    mk(1,0,2'b00,0,12'd0,   0,12'd0,  2'b10)  // R4 start in FAULT no effect
  };

  task automatic check(string req, logic [1:0] exp);
    logic ce, fs;
    ce = (exp == S_R);
    fs = (exp != S_R);
    n_run++;
    if (state_code !== exp || ctrl_en !== ce || force_safe !== fs) begin
      n_fail++;
      $display("FAIL %s: state=%b ctrl_en=%b force_safe=%b expected state=%b ctrl_en=%b force_safe=%b",
               req, state_code, ctrl_en, force_safe, exp, ce, fs);
    end
  endtask

  task automatic idle();
    start_req = 0; clear_req = 0; async_fault = 0; v_valid = 0; i_valid = 0;
    v_sample = 0; i_sample = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); idle(); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    do_reset();
    check("R2 reset state", S_I);

    for (int k = 0; k < NV; k++) begin
      logic [31:0] e;
      e = VEC[k];
      start_req = e[31]; clear_req = e[30]; async_fault = e[29:28];
      v_valid = e[27]; v_sample = e[26:15]; i_valid = e[14]; i_sample = e[13:2];
      repeat (4) @(posedge clk);
      @(negedge clk);
      check($sformatf("R1 vector %0d", k), e[1:0]);
      idle();
      @(negedge clk);
    end

    // R8: exact synchronizer latency from RUN
    idle(); clear_req = 1;
    repeat (2) @(negedge clk);
    clear_req = 0;
    check("R9 back in RUN", S_R);
    async_fault = 2'b01;
    @(negedge clk); check("R8 one edge", S_R);
    @(negedge clk); check("R8 two edges", S_R);
    @(negedge clk); check("R8 three edges", S_F);
    async_fault = 0;

    // R10: fault and start meet in INIT
    do_reset();
    v_sample = 12'd2000; v_valid = 1;
    @(negedge clk);
    v_valid = 0; start_req = 1;
    @(negedge clk);
    start_req = 0;
    check("R10 fault beats start", S_F);

    // R6: over-limit sample latency from RUN
    do_reset();
    start_req = 1; @(negedge clk); start_req = 0;
    check("R2 start accepted", S_R);
    v_sample = 12'd1500; v_valid = 1;
    @(negedge clk); v_valid = 0;
    check("R6 one edge", S_R);
    @(negedge clk);
    check("R6 two edges", S_F);

    // reset from FAULT returns to INIT
    do_reset();
    check("R2 reset from FAULT", S_I);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule